// File: doc/BRIEF.md
# Serial Flash Page Buffer Command Engine

This block is the device side of a serial flash that holds two byte-wide page buffers next to its main array. A host sends one command frame over a SPI-style link (serial clock, serial data in, active-low select). Each frame carries an 8-bit opcode and a 24-bit address. The opcode names one of three whole-page operations, each aimed at one of the two buffers. The first copies a main memory page into the buffer. The second checks a page against the buffer byte for byte. The third refreshes a page: it copies the page into the buffer and then writes the buffer back into the same page.

The opcode and address are captured while select is low, but the operation starts only when select returns high. The page number is taken from a different bit range of the address depending on a page-size mode input, which selects standard or binary page addressing. While an operation runs, an 8-bit status output shows the device as busy. A compare leaves its outcome in a status flag. The main array and the buffers are small parameterised arrays inside the block. The link inputs are brought into the system clock domain by synchronisers, and each internal operation processes one byte per system clock.

Top module: `sflash_page_engine`

## Requirements
- R1: A frame is shifted in MSB first from `si`, one bit per rising edge of `sck`, only while `cs_n` is low. No operation starts before `cs_n` rises, even if all 32 bits arrived earlier.
- R2: Opcode 0x53 copies the addressed main memory page into buffer A. Opcode 0x55 copies it into buffer B. The other buffer is left unchanged.
- R3: Opcode 0x60 compares the addressed page with buffer A, and opcode 0x61 compares it with buffer B. At the end, status bit 6 is 0 if every byte matches and 1 if any byte differs.
- R4: Opcode 0x58 (buffer A) or 0x59 (buffer B) copies the page into the buffer and then programs the buffer back into the same page. Afterwards the buffer equals the page.
- R5: With `page_mode_bin` = 0 the page number is address bits 20:9. With `page_mode_bin` = 1 it is address bits 19:8. All other address bits are ignored. The low log2(PAGES) bits of the page number select the page.
- R6: Status bit 7 is 1 when ready and 0 when busy. Bit 6 is the compare flag. Bits 5:0 are 0. After reset the status is 0x80.
- R7: A copy or a compare keeps the device busy for exactly PAGE_BYTES system clocks. A rewrite keeps it busy for exactly 2*PAGE_BYTES.
- R8: A frame that ends with fewer or more than 32 `sck` rising edges is discarded and starts nothing.
- R9: A frame whose opcode is none of the six above is discarded and starts nothing.
- R10: A frame that ends while the device is busy is ignored. It is not queued for later.
- R11: After reset, byte b of main memory page p holds (3*b + 64*p + 17) mod 256, and both buffers hold zeros.
- R12: Status bit 6 changes only when a compare completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial link clock |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| page_mode_bin | input | 1 | 1 selects binary page addressing, 0 standard |
| status | output | 8 | Bit 7 ready, bit 6 compare differs, bits 5:0 zero |

## Verification
The bench uses the fixed reset contents of memory and buffers to infer every copy and rewrite from later compares. A swapped buffer select or a wrong page would therefore flip a compare result. In binary mode it sends an address whose standard-mode decode points at a different page, so a design that takes the wrong address field loads the wrong buffer contents. It holds select low well after the 32nd bit, sends frames of 31 and 33 bits and an unknown opcode, and sends a compare while a rewrite is still running. A design that launches early, counts bits loosely, or queues busy-time frames would show busy cycles or a changed compare flag. It also counts busy cycles exactly, which catches a rewrite that skips its program-back phase.

// File: rtl/sfpe_pkg.sv
package sfpe_pkg;
  typedef enum logic [1:0] {OP_COPY, OP_CHECK, OP_REFRESH} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CHECK, ST_PROG} st_e;
  typedef struct packed {
    op_e         op;
    logic        buf_b;
    logic [11:0] page;
  } cmd_t;
endpackage

// File: rtl/sfpe_frame_rx.sv
module sfpe_frame_rx #(
  parameter int FRAME_BITS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck,
  input  logic                  cs_n,
  input  logic                  si,
  output logic                  frame_vld,
  output logic [FRAME_BITS-1:0] frame
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sck_sync, cs_sync, si_sync;
  logic                   sck_d, cs_d;
  logic [FRAME_BITS-1:0]  shreg, shreg_n;
  logic [CNT_W-1:0]       cnt, cnt_n;
  logic                   vld_n;
  logic                   sck_s, cs_s, si_s, sck_rise, cs_rise, cs_fall;

  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign si_s     = si_sync[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign cs_fall  = ~cs_s & cs_d;

  always_comb begin
    shreg_n = shreg;
    cnt_n   = cnt;
    if (cs_fall) begin
      shreg_n = '0;
      cnt_n   = '0;
    end else if (!cs_s && sck_rise) begin
      shreg_n = {shreg[FRAME_BITS-2:0], si_s};
      if (cnt != CNT_OVER) cnt_n = cnt + 1'b1;
    end
    vld_n = cs_rise && (cnt == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      cs_sync   <= '1;
      si_sync   <= '0;
      sck_d     <= 1'b0;
      cs_d      <= 1'b1;
      shreg     <= '0;
      cnt       <= '0;
      frame_vld <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      si_sync   <= {si_sync[SYNC_STAGES-2:0], si};
      sck_d     <= sck_s;
      cs_d      <= cs_s;
      shreg     <= shreg_n;
      cnt       <= cnt_n;
      frame_vld <= vld_n;
    end
  end

  assign frame = shreg;

  // R1
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);
  // R8
  bit_count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);
endmodule

// File: rtl/sfpe_cmd_decode.sv
module sfpe_cmd_decode
  import sfpe_pkg::*;
#(
  parameter int PAGE_AW = 12
) (
  input  logic [31:0] frame,
  input  logic        page_mode_bin,
  output cmd_t        cmd,
  output logic        cmd_ok
);
  localparam int STD_LSB = 9;
  localparam int BIN_LSB = 8;

  logic [7:0]  opcode;
  logic [23:0] addr;

  assign opcode = frame[31:24];
  assign addr   = frame[23:0];

  always_comb begin
    cmd_ok    = 1'b1;
    cmd.op    = OP_COPY;
    cmd.buf_b = 1'b0;
    cmd.page  = page_mode_bin ? addr[BIN_LSB +: PAGE_AW] : addr[STD_LSB +: PAGE_AW];
    unique case (opcode)
      8'h53: begin cmd.op = OP_COPY;    cmd.buf_b = 1'b0; end
      8'h55: begin cmd.op = OP_COPY;    cmd.buf_b = 1'b1; end
      8'h60: begin cmd.op = OP_CHECK;   cmd.buf_b = 1'b0; end
      8'h61: begin cmd.op = OP_CHECK;   cmd.buf_b = 1'b1; end
      8'h58: begin cmd.op = OP_REFRESH; cmd.buf_b = 1'b0; end
      8'h59: begin cmd.op = OP_REFRESH; cmd.buf_b = 1'b1; end
      default: cmd_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/sfpe_page_engine.sv
module sfpe_page_engine
  import sfpe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cmd_t cmd,
  output logic busy,
  output logic cmp_diff
);
  localparam int PG_W = $clog2(PAGES);
  localparam int IX_W = $clog2(PAGE_BYTES);
  localparam logic [IX_W-1:0] IX_LAST = IX_W'(PAGE_BYTES - 1);

  logic [7:0] mem  [PAGES][PAGE_BYTES];
  logic [7:0] bufs [2][PAGE_BYTES];

  st_e             st, st_n;
  logic [IX_W-1:0] idx, idx_n;
  logic [PG_W-1:0] page_r, page_n;
  logic            sel_r, sel_n, rw_r, rw_n;
  logic            acc, acc_n, cmp_diff_n;
  logic            buf_we, mem_we, byte_diff, last;

  assign last      = (idx == IX_LAST);
  assign byte_diff = mem[page_r][idx] != bufs[sel_r][idx];

  always_comb begin
    st_n       = st;
    idx_n      = idx;
    page_n     = page_r;
    sel_n      = sel_r;
    rw_n       = rw_r;
    acc_n      = acc;
    cmp_diff_n = cmp_diff;
    buf_we     = 1'b0;
    mem_we     = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        page_n = cmd.page[PG_W-1:0];
        sel_n  = cmd.buf_b;
        rw_n   = (cmd.op == OP_REFRESH);
        idx_n  = '0;
        acc_n  = 1'b0;
        st_n   = (cmd.op == OP_CHECK) ? ST_CHECK : ST_LOAD;
      end
      ST_LOAD: begin
        buf_we = 1'b1;
        idx_n  = last ? '0 : idx + 1'b1;
        if (last) st_n = rw_r ? ST_PROG : ST_IDLE;
      end
      ST_CHECK: begin
        acc_n = acc | byte_diff;
        idx_n = last ? '0 : idx + 1'b1;
        if (last) begin
          cmp_diff_n = acc | byte_diff;
          st_n       = ST_IDLE;
        end
      end
      ST_PROG: begin
        mem_we = 1'b1;
        idx_n  = last ? '0 : idx + 1'b1;
        if (last) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      page_r   <= '0;
      sel_r    <= 1'b0;
      rw_r     <= 1'b0;
      acc      <= 1'b0;
      cmp_diff <= 1'b0;
    end else begin
      st       <= st_n;
      idx      <= idx_n;
      page_r   <= page_n;
      sel_r    <= sel_n;
      rw_r     <= rw_n;
      acc      <= acc_n;
      cmp_diff <= cmp_diff_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          mem[p][b] <= 8'(3 * b + 64 * p + 17);
    end else if (mem_we) begin
      mem[page_r][idx] <= bufs[sel_r][idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < PAGE_BYTES; b++)
          bufs[s][b] <= 8'h00;
    end else if (buf_we) begin
      bufs[sel_r][idx] <= mem[page_r][idx];
    end
  end

  assign busy = (st != ST_IDLE);

  // R12
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_CHECK) |=> $stable(cmp_diff));
  // R4
  prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && $past(st) != ST_PROG) |-> ($past(st) == ST_LOAD && rw_r));
  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IX_LAST);
  // R7
  check_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && last) |=> (st == ST_IDLE));
endmodule

// File: rtl/sflash_page_engine.sv
module sflash_page_engine
  import sfpe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       page_mode_bin,
  output logic [7:0] status
);
  logic        frame_vld, cmd_ok, busy, cmp_diff, start;
  logic [31:0] frame;
  cmd_t        cmd;

  sfpe_frame_rx #(.FRAME_BITS(32), .SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .frame_vld(frame_vld), .frame(frame));

  sfpe_cmd_decode #(.PAGE_AW(12)) u_dec (
    .frame(frame), .page_mode_bin(page_mode_bin), .cmd(cmd), .cmd_ok(cmd_ok));

  assign start = frame_vld & cmd_ok & ~busy;

  sfpe_page_engine #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .busy(busy), .cmp_diff(cmp_diff));

  assign status = {~busy, cmp_diff, 6'b0};

  // R1
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/sflash_page_engine_tb.sv
module sflash_page_engine_tb;
  localparam int NB = 256;
  localparam int HP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic mode = 1'b0;
  logic [7:0] status;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sflash_page_engine #(.PAGES(4), .PAGE_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .page_mode_bin(mode), .status(status));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [23:0] addr,
                            input int nbits, input int hold);
    logic [31:0] d;
    d = {op, addr};
    @(negedge clk); cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 32) ? d[31-i] : 1'b0;
      repeat (HP) @(negedge clk); sck = 1'b1;
      repeat (HP) @(negedge clk); sck = 1'b0;
    end
    repeat (HP + hold) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic busy_count(output int cyc);
    bit seen = 1'b0;
    cyc = 0;
    for (int k = 0; k < 4 * NB; k++) begin
      @(negedge clk);
      if (!status[7]) begin cyc++; seen = 1'b1; end
      else if (seen || k > 20) break;
    end
  endtask

  task automatic run_op(input logic [7:0] op, input int page, input int exp_busy,
                        input string req);
    int c;
    send_frame(op, 24'(page << 9) | 24'hE001FF & 24'hE001FF, 32, 0);
    busy_count(c);
    check(c == exp_busy, req, c, exp_busy);
  endtask

  task automatic cmp_expect(input logic [7:0] op, input int page, input bit exp,
                            input string req);
    run_op(op, page, NB, req);
    check(status[6] == exp, req, status[6], exp);
  endtask

  task automatic t_reset;
    check(status == 8'h80, "R6 reset status", status, 8'h80);
  endtask

  task automatic t_copy;
    cmp_expect(8'h60, 0, 1'b1, "R11 zero buffer vs page0");
    run_op(8'h53, 1, NB, "R7 copy busy length");
    check(status[6] == 1'b1, "R12 flag kept after copy", status[6], 1);
    cmp_expect(8'h60, 1, 1'b0, "R2 buffer A holds page1");
    cmp_expect(8'h60, 2, 1'b1, "R3 page2 differs from A");
    cmp_expect(8'h61, 1, 1'b1, "R2 buffer B untouched");
    run_op(8'h55, 3, NB, "R2 copy into B");
    cmp_expect(8'h61, 3, 1'b0, "R2 buffer B holds page3");
  endtask

  task automatic t_rewrite;
    run_op(8'h59, 2, 2 * NB, "R7 rewrite busy length");
    cmp_expect(8'h61, 2, 1'b0, "R4 buffer B equals page2");
    cmp_expect(8'h60, 1, 1'b0, "R4 buffer A untouched");
    run_op(8'h58, 0, 2 * NB, "R4 rewrite via A");
    cmp_expect(8'h60, 0, 1'b0, "R4 page0 intact and in A");
  endtask

  task automatic t_binmode;
    int c;
    mode = 1'b1;
    send_frame(8'h53, 24'hF0023C, 32, 0);
    busy_count(c);
    check(c == NB, "R5 binary copy busy", c, NB);
    mode = 1'b0;
    cmp_expect(8'h60, 2, 1'b0, "R5 binary field picked page2");
    cmp_expect(8'h60, 1, 1'b1, "R5 not standard field page1");
  endtask

  task automatic t_launch_on_rise;
    int c;
    fork
      send_frame(8'h60, 24'(1 << 9), 32, 60);
      begin
        repeat (40 * HP * 2 + 20) @(negedge clk);
      end
    join_any
    check(status[7] == 1'b1, "R1 no launch while cs low", status[7], 1);
    wait (cs_n == 1'b1);
    busy_count(c);
    check(c == NB, "R1 launch after cs rise", c, NB);
    check(status[6] == 1'b1, "R3 compare page1 vs A differs", status[6], 1);
    cmp_expect(8'h60, 2, 1'b0, "R3 flag back to match");
  endtask

  task automatic t_discard;
    int c;
    send_frame(8'h60, 24'(1 << 9), 31, 0);
    busy_count(c);
    check(c == 0, "R8 31-bit frame", c, 0);
    check(status[6] == 1'b0, "R8 flag kept 31-bit", status[6], 0);
    send_frame(8'h60, 24'(1 << 9), 33, 0);
    busy_count(c);
    check(c == 0, "R8 33-bit frame", c, 0);
    send_frame(8'h62, 24'(1 << 9), 32, 0);
    busy_count(c);
    check(c == 0, "R9 unknown opcode", c, 0);
    check(status[6] == 1'b0, "R9 flag kept", status[6], 0);
  endtask

  task automatic t_busy_ignore;
    int c;
    send_frame(8'h58, 24'(2 << 9), 32, 0);
    send_frame(8'h60, 24'(1 << 9), 32, 0);
    check(status[7] == 1'b0, "R10 still busy at second frame", status[7], 0);
    for (int k = 0; k < 4 * NB && !status[7]; k++) @(negedge clk);
    busy_count(c);
    check(c == 0, "R10 no queued op", c, 0);
    check(status[6] == 1'b0, "R10 flag kept", status[6], 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_copy();
    t_rewrite();
    t_binmode();
    t_launch_on_rise();
    t_discard();
    t_busy_ignore();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule